// File: doc/BRIEF.md
# Lane-Partitioned Masked Vector Subtractor

This block subtracts a second wide vector from a first one, lane by lane. The vector is cut into equal integer lanes of 8, 16 or 32 bits, and every lane wraps modulo its own width. The same hardware serves signed and unsigned data. No status or flag output exists. Only the active part of the vector is computed. The active length is 128, 256 or 512 bits.

A per-lane write mask selects which lanes receive the difference. Lanes that are masked off either keep the old destination value (merge) or are cleared (zero). For 32-bit lanes, a scalar taken from the low 32 bits of the second operand can be replicated to every lane. This applies when that operand comes from memory.

A legacy two-operand form uses the old destination as the minuend and fixes the length at 128 bits. In that form, bits above 128 pass through unchanged. In the three-operand form, every bit above the active length is cleared. The result and its valid flag are registered one clock after the operands are presented.

Top module: `lane_sub_unit`

## Requirements
- R1: Each active lane of `result` equals the low lane-width bits of the minuend minus the subtrahend, wrapping on underflow and overflow with no saturation (for example 0 minus 1 gives all ones in the lane, and the most negative value minus 1 gives the most positive value).
- R2: `width_sel` chooses the lane width: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. No borrow crosses a lane boundary.
- R3: `len_sel` chooses the active length in the three-operand form: 0 = 128, 1 = 256, 2 or 3 = 512 bits. All result bits at or above the active length are 0.
- R4: With `mask_en` = 0, every active lane takes the difference. With `mask_en` = 1, bit j of `lane_mask` governs lane j, counted from the least significant lane, and a 1 takes the difference.
- R5: A lane whose mask bit is 0, with `zero_mode` = 0, takes the matching lane of `old_dst`.
- R6: A lane whose mask bit is 0, with `zero_mode` = 1, becomes all zeros.
- R7: Mask bits at or above the lane count of the selected width and length have no effect on `result`.
- R8: When `bcast_req` = 1, `src_b_mem` = 1 and the width is 32 bits, every lane subtracts `op_b[31:0]`. In any other case `bcast_req` has no effect.
- R9: With `legacy_mode` = 1, the minuend is `old_dst`, the length is 128 bits, and `op_a`, `len_sel`, the mask controls and the broadcast controls have no effect. Result bits above 128 equal `old_dst`.
- R10: `result` and `out_valid` update on the clock edge that samples `in_valid` = 1. When `in_valid` = 0, `out_valid` is 0 after the next edge and `result` holds its value. A synchronous active-high `rst` clears `out_valid` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| width_sel | input | 2 | Lane width select |
| len_sel | input | 2 | Active vector length select (three-operand form) |
| legacy_mode | input | 1 | Two-operand form: old destination is minuend, upper bits kept |
| mask_en | input | 1 | Apply the per-lane write mask |
| zero_mode | input | 1 | Masked-off lanes cleared (1) or merged from old destination (0) |
| bcast_req | input | 1 | Request scalar replication of the second operand |
| src_b_mem | input | 1 | Second operand comes from memory |
| op_a | input | 512 | First source vector (minuend) |
| op_b | input | 512 | Second source vector (subtrahend) |
| old_dst | input | 512 | Previous destination contents |
| lane_mask | input | 64 | Write mask, bit j for lane j |
| out_valid | output | 1 | Result valid |
| result | output | 512 | Registered destination value |

## Verification
Every result is due exactly one rising edge after the cycle in which `in_valid` is high. No other register lies between the operand ports and `result`. The bench changes inputs on the falling edge, lets one rising edge capture them, and compares `result` and `out_valid` on the next falling edge. Hold behaviour is checked two falling edges after `in_valid` drops, with changed operands still on the inputs. Expected vectors come from a per-lane loop over shifted integers, not from byte slices. The two boundary patterns are also compared against closed-form constants: all ones, and the bitwise inverse of the minuend.

// File: rtl/lsub_pkg.sv
`timescale 1ns/1ps
package lsub_pkg;

  localparam int unsigned SLICE_W = 8;

  // Lane width codes carried on width_sel
  localparam logic [1:0] LW_8  = 2'd0;
  localparam logic [1:0] LW_16 = 2'd1;
  localparam logic [1:0] LW_32 = 2'd2;

  // log2 of the number of 8-bit slices in one lane
  function automatic logic [1:0] lane_log2_slices(logic [1:0] w);
    case (w)
      LW_8:    return 2'd0;
      LW_16:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  // Number of slices inside the active length
  function automatic int unsigned active_slices(logic [1:0] l, logic leg, int unsigned base);
    if (leg) return base;
    case (l)
      2'd0:    return base;
      2'd1:    return base * 2;
      default: return base * 4;
    endcase
  endfunction

  // Slice k receives the borrow of slice k-1 only inside a lane
  function automatic logic slice_linked(int unsigned k, logic [1:0] w);
    case (lane_log2_slices(w))
      2'd0:    return 1'b0;
      2'd1:    return k[0];
      default: return (k[1:0] != 2'd0);
    endcase
  endfunction

  // a - b as a + ~b + cin, returning {carry_out, sum}
  function automatic logic [SLICE_W:0] slice_sub(logic [SLICE_W-1:0] a,
                                                 logic [SLICE_W-1:0] b,
                                                 logic cin);
    return {1'b0, a} + {1'b0, ~b} + {{SLICE_W{1'b0}}, cin};
  endfunction

endpackage

// File: rtl/lsub_operand_sel.sv
`timescale 1ns/1ps
module lsub_operand_sel
  import lsub_pkg::*;
#(
  parameter int unsigned VEC_W = 512
) (
  input  logic             legacy_mode,
  input  logic [1:0]       width_sel,
  input  logic             bcast_req,
  input  logic             src_b_mem,
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  input  logic [VEC_W-1:0] old_dst,
  output logic [VEC_W-1:0] minuend,
  output logic [VEC_W-1:0] subtrahend,
  output logic             bcast_eff
);
  localparam int unsigned NUM_DW = VEC_W / 32;

  logic [VEC_W-1:0] b_rep;

  assign bcast_eff = !legacy_mode && bcast_req && src_b_mem &&
                     (lane_log2_slices(width_sel) == 2'd2);

  // Replicate the low 32-bit scalar into every 32-bit lane
  for (genvar d = 0; d < NUM_DW; d++) begin : g_rep
    assign b_rep[d*32 +: 32] = op_b[31:0];
  end

  assign minuend    = legacy_mode ? old_dst : op_a;
  assign subtrahend = bcast_eff ? b_rep : op_b;
endmodule

// File: rtl/lsub_slice_chain.sv
`timescale 1ns/1ps
module lsub_slice_chain
  import lsub_pkg::*;
#(
  parameter int unsigned NUM_SLICES = 64
) (
  input  logic [1:0]                    width_sel,
  input  logic [NUM_SLICES*SLICE_W-1:0] minuend,
  input  logic [NUM_SLICES*SLICE_W-1:0] subtrahend,
  output logic [NUM_SLICES*SLICE_W-1:0] diff,
  output logic [NUM_SLICES-1:0]         carry_link
);
  // Link enables between slice k-1 and slice k
  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_link
    if (k == 0) begin : g_first
      assign carry_link[k] = 1'b0;
    end else begin : g_rest
      assign carry_link[k] = slice_linked(k, width_sel);
    end
  end

  // Ripple through the slices; a cleared link restarts with carry-in 1
  always_comb begin
    logic             c;
    logic             cin;
    logic [SLICE_W:0] s;
    c    = 1'b1;
    diff = '0;
    for (int k = 0; k < NUM_SLICES; k++) begin
      cin = carry_link[k] ? c : 1'b1;
      s   = slice_sub(minuend[k*SLICE_W +: SLICE_W], subtrahend[k*SLICE_W +: SLICE_W], cin);
      diff[k*SLICE_W +: SLICE_W] = s[SLICE_W-1:0];
      c   = s[SLICE_W];
    end
  end
endmodule

// File: rtl/lsub_lane_ctl.sv
`timescale 1ns/1ps
module lsub_lane_ctl
  import lsub_pkg::*;
#(
  parameter int unsigned NUM_SLICES  = 64,
  parameter int unsigned BASE_SLICES = 16
) (
  input  logic [1:0]            width_sel,
  input  logic [1:0]            len_sel,
  input  logic                  legacy_mode,
  input  logic                  mask_en,
  input  logic                  zero_mode,
  input  logic [NUM_SLICES-1:0] lane_mask,
  output logic [NUM_SLICES-1:0] byte_take,
  output logic [NUM_SLICES-1:0] byte_keep_old
);
  logic [1:0]  lg;
  logic [31:0] act_cnt;

  assign lg      = lane_log2_slices(width_sel);
  assign act_cnt = active_slices(len_sel, legacy_mode, BASE_SLICES);

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    logic mbit;
    logic active;
    // Mask bit of the lane that owns slice k
    assign mbit   = (lg == 2'd0) ? lane_mask[k] :
                    (lg == 2'd1) ? lane_mask[k/2] : lane_mask[k/4];
    assign active = (32'(k) < act_cnt);
    assign byte_take[k]     = active && (legacy_mode || !mask_en || mbit);
    assign byte_keep_old[k] = active ? (!byte_take[k] && !zero_mode) : legacy_mode;
  end
endmodule

// File: rtl/lane_sub_unit.sv
`timescale 1ns/1ps
module lane_sub_unit
  import lsub_pkg::*;
#(
  parameter int unsigned VEC_W  = 512,
  parameter int unsigned BASE_W = 128
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [1:0]                 width_sel,
  input  logic [1:0]                 len_sel,
  input  logic                       legacy_mode,
  input  logic                       mask_en,
  input  logic                       zero_mode,
  input  logic                       bcast_req,
  input  logic                       src_b_mem,
  input  logic [VEC_W-1:0]           op_a,
  input  logic [VEC_W-1:0]           op_b,
  input  logic [VEC_W-1:0]           old_dst,
  input  logic [VEC_W/SLICE_W-1:0]   lane_mask,
  output logic                       out_valid,
  output logic [VEC_W-1:0]           result
);
  localparam int unsigned NB      = VEC_W / SLICE_W;
  localparam int unsigned BASE_NB = BASE_W / SLICE_W;

  logic [VEC_W-1:0] minuend;
  logic [VEC_W-1:0] subtrahend;
  logic [VEC_W-1:0] diff;
  logic [VEC_W-1:0] next_result;
  logic [NB-1:0]    carry_link;
  logic [NB-1:0]    byte_take;
  logic [NB-1:0]    byte_keep_old;
  logic             bcast_eff;

  lsub_operand_sel #(.VEC_W(VEC_W)) u_opsel (
    .legacy_mode (legacy_mode),
    .width_sel   (width_sel),
    .bcast_req   (bcast_req),
    .src_b_mem   (src_b_mem),
    .op_a        (op_a),
    .op_b        (op_b),
    .old_dst     (old_dst),
    .minuend     (minuend),
    .subtrahend  (subtrahend),
    .bcast_eff   (bcast_eff)
  );

  lsub_slice_chain #(.NUM_SLICES(NB)) u_chain (
    .width_sel  (width_sel),
    .minuend    (minuend),
    .subtrahend (subtrahend),
    .diff       (diff),
    .carry_link (carry_link)
  );

  lsub_lane_ctl #(.NUM_SLICES(NB), .BASE_SLICES(BASE_NB)) u_ctl (
    .width_sel     (width_sel),
    .len_sel       (len_sel),
    .legacy_mode   (legacy_mode),
    .mask_en       (mask_en),
    .zero_mode     (zero_mode),
    .lane_mask     (lane_mask),
    .byte_take     (byte_take),
    .byte_keep_old (byte_keep_old)
  );

  // Per-slice write select: difference, old destination or zero
  for (genvar k = 0; k < NB; k++) begin : g_wsel
    assign next_result[k*SLICE_W +: SLICE_W] =
      byte_take[k]     ? diff[k*SLICE_W +: SLICE_W] :
      byte_keep_old[k] ? old_dst[k*SLICE_W +: SLICE_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_result;
    end
  end
endmodule

// File: rtl/lane_sub_unit_chk.sv
`timescale 1ns/1ps
module lane_sub_unit_chk #(
  parameter int unsigned VEC_W  = 512,
  parameter int unsigned BASE_W = 128
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [1:0]            width_sel,
  input logic [1:0]            len_sel,
  input logic                  legacy_mode,
  input logic                  mask_en,
  input logic                  zero_mode,
  input logic                  mask_lsb,
  input logic [7:0]            op_a_lo,
  input logic [7:0]            op_b_lo,
  input logic [7:0]            old_lo,
  input logic [VEC_W-1:BASE_W] old_hi,
  input logic                  out_valid,
  input logic [7:0]            result_lo,
  input logic [VEC_W-1:BASE_W] result_hi,
  input logic [VEC_W/8-1:0]    carry_link,
  input logic [VEC_W/8-1:BASE_W/8] take_hi,
  input logic                  bcast_eff
);
  p_valid_follow_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_drop_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_byte_unlinked_r2: assert property (@(posedge clk) disable iff (rst)
    (width_sel == 2'd0) |-> (carry_link == '0));

  p_upper_cleared_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !legacy_mode && len_sel == 2'd0) |=> (result_hi == '0));

  p_no_take_above_len_r3: assert property (@(posedge clk) disable iff (rst)
    (!legacy_mode && len_sel == 2'd0) |-> (take_hi == '0));

  p_lane0_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !legacy_mode && !mask_en && width_sel == 2'd0)
      |=> (result_lo == $past(op_a_lo - op_b_lo)));

  p_merge_lane0_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !legacy_mode && mask_en && !zero_mode && !mask_lsb)
      |=> (result_lo == $past(old_lo)));

  p_zero_lane0_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !legacy_mode && mask_en && zero_mode && !mask_lsb)
      |=> (result_lo == 8'd0));

  p_bcast_scope_r8: assert property (@(posedge clk) disable iff (rst)
    bcast_eff |-> (width_sel[1] && !legacy_mode));

  p_legacy_upper_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legacy_mode) |=> (result_hi == $past(old_hi)));
endmodule

bind lane_sub_unit lane_sub_unit_chk #(.VEC_W(VEC_W), .BASE_W(BASE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .width_sel   (width_sel),
  .len_sel     (len_sel),
  .legacy_mode (legacy_mode),
  .mask_en     (mask_en),
  .zero_mode   (zero_mode),
  .mask_lsb    (lane_mask[0]),
  .op_a_lo     (op_a[7:0]),
  .op_b_lo     (op_b[7:0]),
  .old_lo      (old_dst[7:0]),
  .old_hi      (old_dst[VEC_W-1:BASE_W]),
  .out_valid   (out_valid),
  .result_lo   (result[7:0]),
  .result_hi   (result[VEC_W-1:BASE_W]),
  .carry_link  (carry_link),
  .take_hi     (byte_take[VEC_W/8-1:BASE_W/8]),
  .bcast_eff   (bcast_eff)
);

// File: tb/lane_sub_unit_tb.sv
`timescale 1ns/1ps
module lane_sub_unit_tb;
  localparam int VW = 512;
  localparam int NB = VW / 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [1:0]    width_sel, len_sel;
  logic          legacy_mode, mask_en, zero_mode, bcast_req, src_b_mem;
  logic [VW-1:0] op_a, op_b, old_dst;
  logic [NB-1:0] lane_mask;
  logic          out_valid;
  logic [VW-1:0] result;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lane_sub_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .width_sel(width_sel),
    .len_sel(len_sel), .legacy_mode(legacy_mode), .mask_en(mask_en),
    .zero_mode(zero_mode), .bcast_req(bcast_req), .src_b_mem(src_b_mem),
    .op_a(op_a), .op_b(op_b), .old_dst(old_dst), .lane_mask(lane_mask),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  // Per-lane reference built on shifted integers
  function automatic logic [VW-1:0] model(logic [1:0] w, logic [1:0] l, logic leg,
      logic men, logic zm, logic bc, logic mem,
      logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] d, logic [NB-1:0] m);
    int lw, vl;
    logic [31:0] lmask, xa, xb, od, val;
    logic [VW-1:0] r, lm_v;
    lw = (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
    vl = (l == 2'd0) ? 128 : (l == 2'd1) ? 256 : 512;
    if (leg) begin vl = 128; a = d; end
    r = leg ? d : '0;
    lmask = (lw == 32) ? 32'hFFFF_FFFF : ((32'd1 << lw) - 32'd1);
    for (int j = 0; j < vl / lw; j++) begin
      xa = 32'(a >> (j*lw)) & lmask;
      xb = (!leg && bc && mem && lw == 32) ? b[31:0] : (32'(b >> (j*lw)) & lmask);
      od = 32'(d >> (j*lw)) & lmask;
      if (leg || !men || m[j]) val = (xa - xb) & lmask;
      else if (zm)             val = '0;
      else                     val = od;
      lm_v = {{(VW-32){1'b0}}, lmask} << (j*lw);
      r = (r & ~lm_v) | ({{(VW-32){1'b0}}, val} << (j*lw));
    end
    return r;
  endfunction

  task automatic check(string tag, logic exp_v, logic [VW-1:0] exp_r);
    n_vec++;
    if (out_valid !== exp_v || result !== exp_r) begin
      n_bad++;
      $display("FAIL %s: valid=%b result=%h expected valid=%b result=%h",
               tag, out_valid, result, exp_v, exp_r);
    end
  endtask

  // Apply current inputs for one cycle, check on the following falling edge
  task automatic fire(string tag, logic [VW-1:0] exp_r);
    in_valid = 1'b1;
    @(negedge clk);
    check(tag, 1'b1, exp_r);
    in_valid = 1'b0;
  endtask

  function automatic logic [VW-1:0] cur_model();
    return model(width_sel, len_sel, legacy_mode, mask_en, zero_mode, bcast_req,
                 src_b_mem, op_a, op_b, old_dst, lane_mask);
  endfunction

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b1;
    width_sel = 2'd0; len_sel = 2'd0; legacy_mode = 1'b0; mask_en = 1'b0;
    zero_mode = 1'b0; bcast_req = 1'b0; src_b_mem = 1'b0;
    op_a = rand_vec(); op_b = rand_vec(); old_dst = rand_vec(); lane_mask = '0;
    repeat (3) @(negedge clk);
    in_valid = 1'b0; rst = 1'b0;
    @(negedge clk);
    check("R10 reset state", 1'b0, '0);
  endtask

  task automatic t_sweep();
    for (int w = 0; w < 4; w++)
      for (int l = 0; l < 3; l++)
        for (int mm = 0; mm < 4; mm++)
          for (int bc = 0; bc < 2; bc++) begin
            string tag;
            width_sel = 2'(w); len_sel = 2'(l); legacy_mode = 1'b0;
            mask_en = (mm != 0); zero_mode = (mm == 2);
            bcast_req = 1'(bc); src_b_mem = (mm != 3);
            op_a = rand_vec(); op_b = rand_vec(); old_dst = rand_vec();
            lane_mask = {$urandom(), $urandom()};
            if (mm == 1)      tag = "R4/R5 merge sweep";
            else if (mm == 2) tag = "R6 zero sweep";
            else if (bc == 1) tag = "R8 broadcast sweep";
            else              tag = "R1/R2/R3 sweep";
            fire(tag, cur_model());
          end
  endtask

  task automatic t_boundary();
    for (int w = 0; w < 3; w++) begin
      int lb;
      lb = 1 << w;
      width_sel = 2'(w); len_sel = 2'd2; legacy_mode = 1'b0; mask_en = 1'b0;
      zero_mode = 1'b0; bcast_req = 1'b0; src_b_mem = 1'b0;
      old_dst = rand_vec(); lane_mask = '0;
      op_a = '0; op_b = '0;
      for (int k = 0; k < NB; k++) if (k % lb == 0) op_b[k*8 +: 8] = 8'h01;
      fire("R1 zero minus one", {VW{1'b1}});
      for (int k = 0; k < NB; k++) if (k % lb == lb - 1) op_a[k*8 +: 8] = 8'h80;
      fire("R1/R2 most negative minus one", ~op_a);
    end
  endtask

  task automatic t_legacy();
    logic [VW-1:0] exp_r;
    width_sel = 2'd1; len_sel = 2'd2; legacy_mode = 1'b1; mask_en = 1'b1;
    zero_mode = 1'b1; bcast_req = 1'b1; src_b_mem = 1'b1;
    op_a = rand_vec(); op_b = rand_vec(); old_dst = rand_vec(); lane_mask = '0;
    exp_r = model(2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, op_b, old_dst, '0);
    fire("R9 legacy form", exp_r);
    op_a = rand_vec(); width_sel = 2'd2; len_sel = 2'd1;
    exp_r = model(2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, op_b, old_dst, '0);
    fire("R9 legacy ignores op_a and length", exp_r);
  endtask

  task automatic t_mask_high();
    legacy_mode = 1'b0; mask_en = 1'b1; zero_mode = 1'b1; bcast_req = 1'b0;
    src_b_mem = 1'b0;
    op_a = rand_vec(); op_b = rand_vec(); old_dst = rand_vec();
    width_sel = 2'd2; len_sel = 2'd0; lane_mask = 64'hFFFF_FFFF_FFFF_FFF5;
    fire("R7 mask above 4 lanes", model(2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0,
                                        op_a, op_b, old_dst, 64'h5));
    width_sel = 2'd0; len_sel = 2'd1; lane_mask = 64'hFFFF_FFFF_0F0F_3C3C;
    zero_mode = 1'b0;
    fire("R7 mask above 32 lanes", model(2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0,
                                         op_a, op_b, old_dst, 64'h0F0F_3C3C));
  endtask

  task automatic t_hold();
    logic [VW-1:0] held;
    width_sel = 2'd1; len_sel = 2'd1; legacy_mode = 1'b0; mask_en = 1'b0;
    zero_mode = 1'b0; bcast_req = 1'b0; src_b_mem = 1'b0;
    op_a = rand_vec(); op_b = rand_vec(); old_dst = rand_vec(); lane_mask = '0;
    held = cur_model();
    fire("R10 capture", held);
    op_a = rand_vec(); op_b = rand_vec();
    repeat (2) @(negedge clk);
    check("R10 hold while idle", 1'b0, held);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sweep();
    t_boundary();
    t_legacy();
    t_mask_high();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule